// File: doc/BRIEF.md
# Flash Word Programming Sequencer

This block is a host-side engine that writes a contiguous range of words into a parallel flash that takes commands. The flash runs its own internal program algorithm. After a one-cycle start pulse the sequencer works through the range from the first address to the last. For each address it fetches the intended word from a data-source port. It then writes the unlock-and-program command run to the flash and reads the target location until the status bit shows the internal algorithm has finished. Last, it reads the word back once more and compares it in full.

A clean verify moves the engine to the next address. After the last address verifies, the engine reports completion with a one-cycle pulse. A verify mismatch, or a status that never settles within a bounded number of reads, stops the run. The engine then keeps an error flag and the address at which it stopped until the next accepted start. The flash side is a plain bus master: registered address and write data, a write strobe, a read strobe, and read data that returns a fixed number of cycles after each read strobe.

Top module: `fprog_seq`

## Requirements
- R1: After reset `busy_o`, `done_o`, `err_o`, `bus_we_o` and `bus_re_o` are all 0, and while `busy_o` is 0 neither bus strobe is raised.
- R2: Each word begins with four write strobes in consecutive cycles, in this order: data 0xAA to address 0x555, data 0x55 to address 0x2AA, data 0xA0 to address 0x555, then the intended word to the target address. No other write occurs for that word.
- R3: After the command run, the engine issues single-cycle read strobes at the target address. It issues them one at a time, each after the previous read's data has returned. It keeps reading while bit 7 of the returned data differs from bit 7 of the intended word.
- R4: When a status read shows bit 7 equal to the intended word's bit 7, exactly one further read of the target follows, and the engine compares all returned bits with the intended word.
- R5: On a matching verify with the target below the last address, the next command run targets the address plus one. Every address from first to last inclusive is programmed exactly once, in ascending order.
- R6: After the last address verifies, `done_o` is high for exactly one cycle, `busy_o` falls in the same cycle, and `err_o` stays 0.
- R7: A verify mismatch sets `err_o`, loads `err_addr_o` with the failing address, clears `busy_o`, and issues no further bus cycle and no done pulse.
- R8: If `POLL_MAX` consecutive status reads of one word all show bit 7 unequal, the run stops with `err_o` set and `err_addr_o` holding that address, and no verify read is made.
- R9: A start pulse while `busy_o` is high is ignored: the running range continues unchanged and no address of the second range is written.
- R10: Write and read strobes are never high in the same cycle, and a read strobe never lasts more than one cycle.
- R11: `src_addr_o` shows the current target address, and the word written in the fourth command write equals `src_data_i` as presented for that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| first_addr_i | input | AW | First address of the range |
| last_addr_i | input | AW | Last address of the range, inclusive |
| src_addr_o | output | AW | Address whose data is requested |
| src_data_i | input | DW | Intended word for `src_addr_o` |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at successful completion |
| err_o | output | 1 | Run stopped on mismatch or timeout; held until the next start |
| err_addr_o | output | AW | Address at which the run stopped |
| bus_addr_o | output | AW | Flash bus address |
| bus_wdata_o | output | DW | Flash bus write data |
| bus_we_o | output | 1 | One-cycle write strobe |
| bus_re_o | output | 1 | One-cycle read strobe |
| bus_rdata_i | input | DW | Read data, valid `RD_LAT` cycles after a read strobe |

## Verification
The properties assume that the flash returns read data exactly `RD_LAT` cycles after each read strobe. They also assume that `first_addr_i` is not above `last_addr_i` and that `src_data_i` is a function of `src_addr_o` alone. The bench's flash model holds the read delay as a pipeline of the same depth. Every range the bench issues is ascending and lies inside the address space, and the source word is an arithmetic function of the address. The model also reports any write that arrives while its internal algorithm is still running.

// File: rtl/fprog_pkg.sv
package fprog_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_CMD,
      ST_POLL_RD,
      ST_POLL_WT,
      ST_VER_RD,
      ST_VER_WT
   } fprog_state_t;

   localparam int CMD_STEPS = 4;

endpackage

// File: rtl/fprog_cmd_gen.sv
module fprog_cmd_gen #(
   parameter int AW       = 12,
   parameter int DW       = 8,
   parameter int UNLK_A1  = 'h555,
   parameter int UNLK_A2  = 'h2AA,
   parameter int CODE_1   = 'hAA,
   parameter int CODE_2   = 'h55,
   parameter int CODE_PGM = 'hA0
) (
   input  logic [1:0]    step_i,
   input  logic [AW-1:0] tgt_addr_i,
   input  logic [DW-1:0] tgt_data_i,
   output logic [AW-1:0] addr_o,
   output logic [DW-1:0] data_o
);

   localparam logic [AW-1:0] A1 = AW'(UNLK_A1);
   localparam logic [AW-1:0] A2 = AW'(UNLK_A2);
   localparam logic [DW-1:0] C1 = DW'(CODE_1);
   localparam logic [DW-1:0] C2 = DW'(CODE_2);
   localparam logic [DW-1:0] CP = DW'(CODE_PGM);

   always_comb begin
      case (step_i)
         2'd0:    begin addr_o = A1;         data_o = C1;         end
         2'd1:    begin addr_o = A2;         data_o = C2;         end
         2'd2:    begin addr_o = A1;         data_o = CP;         end
         default: begin addr_o = tgt_addr_i; data_o = tgt_data_i; end
      endcase
   end

endmodule

// File: rtl/fprog_rd_track.sv
module fprog_rd_track #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue_i,
   output logic valid_o
);

   generate
      if (LAT == 1) begin : g_single
         logic v_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v_q <= 1'b0;
            else        v_q <= issue_i;
         end
         assign valid_o = v_q;
      end else begin : g_shift
         logic [LAT-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[LAT-2:0], issue_i};
         end
         assign valid_o = sh_q[LAT-1];
      end
   endgenerate

endmodule

// File: rtl/fprog_poll_ctr.sv
module fprog_poll_ctr #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic last_o
);

   generate
      if (LIMIT == 1) begin : g_one
         assign last_o = 1'b1;
      end else begin : g_cnt
         localparam int CW = $clog2(LIMIT);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt_q <= '0;
            else if (clr_i) cnt_q <= '0;
            else if (inc_i) cnt_q <= cnt_q + CW'(1);
         end
         assign last_o = (cnt_q == CW'(LIMIT - 1));
      end
   endgenerate

endmodule

// File: rtl/fprog_seq.sv
module fprog_seq
   import fprog_pkg::*;
#(
   parameter int AW       = 12,
   parameter int DW       = 8,
   parameter int RD_LAT   = 2,
   parameter int POLL_MAX = 64,
   parameter int STAT_BIT = 7,
   parameter int UNLK_A1  = 'h555,
   parameter int UNLK_A2  = 'h2AA,
   parameter int CODE_1   = 'hAA,
   parameter int CODE_2   = 'h55,
   parameter int CODE_PGM = 'hA0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] first_addr_i,
   input  logic [AW-1:0] last_addr_i,
   output logic [AW-1:0] src_addr_o,
   input  logic [DW-1:0] src_data_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          err_o,
   output logic [AW-1:0] err_addr_o,
   output logic [AW-1:0] bus_addr_o,
   output logic [DW-1:0] bus_wdata_o,
   output logic          bus_we_o,
   output logic          bus_re_o,
   input  logic [DW-1:0] bus_rdata_i
);

   localparam logic [1:0] LAST_STEP = 2'(CMD_STEPS - 1);

   generate
      if (RD_LAT < 1)               begin : g_bad_lat  $error("RD_LAT must be at least 1");        end
      if (POLL_MAX < 1)             begin : g_bad_poll $error("POLL_MAX must be at least 1");      end
      if (STAT_BIT >= DW)           begin : g_bad_stat $error("STAT_BIT must lie inside the word"); end
      if (UNLK_A1 >= (1 << AW) || UNLK_A2 >= (1 << AW))
                                    begin : g_bad_aw   $error("AW too narrow for unlock addresses"); end
      if (CODE_1 >= (1 << DW) || CODE_2 >= (1 << DW) || CODE_PGM >= (1 << DW))
                                    begin : g_bad_dw   $error("DW too narrow for command codes");  end
   endgenerate

   fprog_state_t  st_q;
   logic [1:0]    step_q;
   logic [AW-1:0] cur_q;
   logic [AW-1:0] last_q;
   logic [DW-1:0] wdat_q;

   logic [AW-1:0] cg_addr;
   logic [DW-1:0] cg_data;
   logic          rd_vld;
   logic          poll_last;
   logic          stat_ok;
   logic          poll_inc;
   logic          poll_clr;

   fprog_cmd_gen #(
      .AW(AW), .DW(DW),
      .UNLK_A1(UNLK_A1), .UNLK_A2(UNLK_A2),
      .CODE_1(CODE_1), .CODE_2(CODE_2), .CODE_PGM(CODE_PGM)
   ) u_cmd (
      .step_i    (step_q),
      .tgt_addr_i(cur_q),
      .tgt_data_i(wdat_q),
      .addr_o    (cg_addr),
      .data_o    (cg_data)
   );

   fprog_rd_track #(.LAT(RD_LAT)) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .issue_i(bus_re_o),
      .valid_o(rd_vld)
   );

   assign stat_ok  = (bus_rdata_i[STAT_BIT] == wdat_q[STAT_BIT]);
   assign poll_inc = (st_q == ST_POLL_WT) && rd_vld && !stat_ok;
   assign poll_clr = (st_q == ST_LOAD);

   fprog_poll_ctr #(.LIMIT(POLL_MAX)) u_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (poll_clr),
      .inc_i (poll_inc),
      .last_o(poll_last)
   );

   assign src_addr_o = cur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         step_q      <= '0;
         cur_q       <= '0;
         last_q      <= '0;
         wdat_q      <= '0;
         busy_o      <= 1'b0;
         done_o      <= 1'b0;
         err_o       <= 1'b0;
         err_addr_o  <= '0;
         bus_addr_o  <= '0;
         bus_wdata_o <= '0;
         bus_we_o    <= 1'b0;
         bus_re_o    <= 1'b0;
      end else begin
         done_o   <= 1'b0;
         bus_we_o <= 1'b0;
         bus_re_o <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  busy_o <= 1'b1;
                  err_o  <= 1'b0;
                  cur_q  <= first_addr_i;
                  last_q <= last_addr_i;
                  st_q   <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               wdat_q <= src_data_i;
               step_q <= '0;
               st_q   <= ST_CMD;
            end
            ST_CMD: begin
               bus_we_o    <= 1'b1;
               bus_addr_o  <= cg_addr;
               bus_wdata_o <= cg_data;
               step_q      <= step_q + 2'd1;
               if (step_q == LAST_STEP) st_q <= ST_POLL_RD;
            end
            ST_POLL_RD: begin
               bus_re_o   <= 1'b1;
               bus_addr_o <= cur_q;
               st_q       <= ST_POLL_WT;
            end
            ST_POLL_WT: begin
               if (rd_vld) begin
                  if (stat_ok) begin
                     st_q <= ST_VER_RD;
                  end else if (poll_last) begin
                     err_o      <= 1'b1;
                     err_addr_o <= cur_q;
                     busy_o     <= 1'b0;
                     st_q       <= ST_IDLE;
                  end else begin
                     st_q <= ST_POLL_RD;
                  end
               end
            end
            ST_VER_RD: begin
               bus_re_o   <= 1'b1;
               bus_addr_o <= cur_q;
               st_q       <= ST_VER_WT;
            end
            ST_VER_WT: begin
               if (rd_vld) begin
                  if (bus_rdata_i != wdat_q) begin
                     err_o      <= 1'b1;
                     err_addr_o <= cur_q;
                     busy_o     <= 1'b0;
                     st_q       <= ST_IDLE;
                  end else if (cur_q == last_q) begin
                     done_o <= 1'b1;
                     busy_o <= 1'b0;
                     st_q   <= ST_IDLE;
                  end else begin
                     cur_q <= cur_q + AW'(1);
                     st_q  <= ST_LOAD;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fprog_seq_chk.sv
module fprog_seq_chk #(
   parameter int AW      = 12,
   parameter int DW      = 8,
   parameter int UNLK_A1 = 'h555,
   parameter int CODE_1  = 'hAA
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy_o,
   input logic          done_o,
   input logic          err_o,
   input logic [AW-1:0] bus_addr_o,
   input logic [DW-1:0] bus_wdata_o,
   input logic          bus_we_o,
   input logic          bus_re_o
);

   assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!bus_we_o && !bus_re_o));

   assert_first_unlock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_we_o) |-> (bus_addr_o == AW'(UNLK_A1) && bus_wdata_o == DW'(CODE_1)));

   assert_cmd_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_we_o) |=> bus_we_o);

   assert_read_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_re_o |=> !bus_re_o);

   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && !err_o));

   assert_err_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_o) |-> (!busy_o && !done_o));

   assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we_o && bus_re_o));

endmodule

bind fprog_seq fprog_seq_chk #(
   .AW(AW), .DW(DW), .UNLK_A1(UNLK_A1), .CODE_1(CODE_1)
) u_fprog_seq_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .err_o      (err_o),
   .bus_addr_o (bus_addr_o),
   .bus_wdata_o(bus_wdata_o),
   .bus_we_o   (bus_we_o),
   .bus_re_o   (bus_re_o)
);

// File: tb/fprog_seq_bench.sv
module fprog_seq_bench;

   localparam int AW       = 12;
   localparam int DW       = 8;
   localparam int RD_LAT   = 2;
   localparam int POLL_MAX = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] first_addr_i = '0;
   logic [AW-1:0] last_addr_i = '0;
   logic [AW-1:0] src_addr_o;
   logic [DW-1:0] src_data_i;
   logic          busy_o, done_o, err_o;
   logic [AW-1:0] err_addr_o;
   logic [AW-1:0] bus_addr_o;
   logic [DW-1:0] bus_wdata_o;
   logic          bus_we_o, bus_re_o;
   logic [DW-1:0] bus_rdata_i;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   function automatic logic [DW-1:0] dfun(input logic [AW-1:0] a);
      return DW'(a * 37 + 5);
   endfunction

   assign src_data_i = dfun(src_addr_o);

   fprog_seq #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT), .POLL_MAX(POLL_MAX)) u_fprog_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .first_addr_i(first_addr_i), .last_addr_i(last_addr_i),
      .src_addr_o(src_addr_o), .src_data_i(src_data_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .err_addr_o(err_addr_o),
      .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
      .bus_we_o(bus_we_o), .bus_re_o(bus_re_o), .bus_rdata_i(bus_rdata_i)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // flash model
   logic [DW-1:0] mem [1 << AW];
   logic [DW-1:0] pipe [RD_LAT];
   int            cmd_st = 0;
   int            busy_left = 0;
   int            exp_busy = 0;
   int            reads = 0;
   int            targets = 0;
   int            n_done = 0;
   bit            word_open = 0;
   logic [AW-1:0] exp_addr = '0;
   logic [DW-1:0] prog_data = '0;
   bit            bad_en = 0, stuck_en = 0;
   logic [AW-1:0] bad_addr = '0, stuck_addr = '0;

   assign bus_rdata_i = pipe[RD_LAT-1];

   initial begin
      for (int i = 0; i < (1 << AW); i++) mem[i] = '1;
      for (int i = 0; i < RD_LAT; i++) pipe[i] = '0;
   end

   always @(posedge clk) begin
      if (rst_n) begin
         if (bus_we_o) begin
            if (busy_left > 0)
               chk(0, "R2", "write during internal algorithm", bus_addr_o, 0);
            case (cmd_st)
               0: chk(bus_addr_o == 12'h555 && bus_wdata_o == 8'hAA, "R2", "unlock write 1",
                      {bus_addr_o, bus_wdata_o}, {12'h555, 8'hAA});
               1: chk(bus_addr_o == 12'h2AA && bus_wdata_o == 8'h55, "R2", "unlock write 2",
                      {bus_addr_o, bus_wdata_o}, {12'h2AA, 8'h55});
               2: chk(bus_addr_o == 12'h555 && bus_wdata_o == 8'hA0, "R2", "program code write",
                      {bus_addr_o, bus_wdata_o}, {12'h555, 8'hA0});
               default: begin
                  if (word_open)
                     chk(reads == exp_busy + 2, "R4", "reads per word", reads, exp_busy + 2);
                  chk(bus_addr_o == exp_addr, "R5", "target address order", bus_addr_o, exp_addr);
                  chk(bus_wdata_o == dfun(bus_addr_o), "R11", "programmed word", bus_wdata_o,
                      dfun(bus_addr_o));
                  mem[bus_addr_o] = mem[bus_addr_o] &
                                    ((bad_en && bus_addr_o == bad_addr) ? (bus_wdata_o ^ 8'h01)
                                                                         : bus_wdata_o);
                  prog_data = bus_wdata_o;
                  busy_left = (stuck_en && bus_addr_o == stuck_addr) ? 1000000
                                                                       : int'(bus_addr_o % 4);
                  exp_busy  = busy_left;
                  reads     = 0;
                  word_open = 1;
                  exp_addr  = exp_addr + 1'b1;
                  targets++;
               end
            endcase
            cmd_st = (cmd_st + 1) % 4;
         end
         for (int i = RD_LAT - 1; i > 0; i--) pipe[i] <= pipe[i-1];
         if (bus_re_o) begin
            reads++;
            if (bus_addr_o != exp_addr - 1'b1)
               chk(0, "R3", "read address", bus_addr_o, exp_addr - 1'b1);
            if (busy_left > 0) begin
               pipe[0] <= {~prog_data[7], 7'h00};
               busy_left--;
            end else begin
               pipe[0] <= mem[bus_addr_o];
            end
         end else begin
            pipe[0] <= '0;
         end
      end
   end

   always @(negedge clk) if (rst_n && done_o) n_done++;

   task automatic launch(input logic [AW-1:0] f, input logic [AW-1:0] l);
      @(negedge clk);
      first_addr_i = f;
      last_addr_i  = l;
      start_i      = 1'b1;
      exp_addr     = f;
      word_open    = 0;
      targets      = 0;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_end();
      int n = 0;
      while (!(done_o || err_o) && n < 20000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic run_ok(input logic [AW-1:0] f, input logic [AW-1:0] l);
      int d0;
      d0 = n_done;
      launch(f, l);
      wait_end();
      chk(done_o && !err_o && !busy_o, "R6", "done with busy low", {done_o, err_o, busy_o}, 3'b100);
      chk(targets == int'(l - f) + 1, "R5", "words programmed", targets, int'(l - f) + 1);
      chk(reads == exp_busy + 2, "R3", "status and verify reads of last word", reads, exp_busy + 2);
      for (int a = int'(f); a <= int'(l); a++)
         chk(mem[a] == dfun(AW'(a)), "R5", "array content", mem[a], dfun(AW'(a)));
      @(negedge clk);
      chk(!done_o, "R6", "done lasts one cycle", done_o, 0);
      chk(n_done == d0 + 1, "R6", "single done pulse", n_done, d0 + 1);
   endtask

   initial begin
      int d0;
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int d0;
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o && !err_o && !bus_we_o && !bus_re_o, "R1", "reset outputs",
          {busy_o, done_o, err_o, bus_we_o, bus_re_o}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!busy_o && !bus_we_o && !bus_re_o, "R1", "idle after reset",
          {busy_o, bus_we_o, bus_re_o}, 0);

      // sweep of range lengths and status-busy patterns
      for (int k = 0; k < 4; k++)
         run_ok(AW'(16 + k * 32), AW'(16 + k * 32 + k * 5));
      run_ok(12'hFFC, 12'hFFF);
      run_ok(12'h100, 12'h100);

      // R7: verify mismatch
      bad_en = 1; bad_addr = 12'h403;
      d0 = n_done;
      launch(12'h400, 12'h407);
      wait_end();
      chk(err_o && !busy_o, "R7", "error on mismatch", {err_o, busy_o}, 2'b10);
      chk(err_addr_o == 12'h403, "R7", "mismatch address", err_addr_o, 12'h403);
      chk(targets == 4, "R7", "words before stop", targets, 4);
      repeat (20) @(negedge clk);
      chk(mem[12'h404] == 8'hFF && n_done == d0, "R7", "no bus cycle or done after error",
          {mem[12'h404], 8'(n_done - d0)}, 16'hFF00);
      bad_en = 0;

      // R8: status never settles
      stuck_en = 1; stuck_addr = 12'h502;
      launch(12'h500, 12'h505);
      wait_end();
      chk(err_o && err_addr_o == 12'h502, "R8", "timeout address", err_addr_o, 12'h502);
      chk(reads == POLL_MAX, "R8", "status reads before timeout, no verify", reads, POLL_MAX);
      repeat (10) @(negedge clk);
      chk(mem[12'h503] == 8'hFF, "R8", "no later word after timeout", mem[12'h503], 8'hFF);
      stuck_en = 0; busy_left = 0;

      // R9: start while busy
      d0 = n_done;
      launch(12'h200, 12'h207);
      repeat (30) @(negedge clk);
      chk(busy_o, "R9", "still busy at second start", busy_o, 1);
      first_addr_i = 12'h300; last_addr_i = 12'h300; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_end();
      chk(done_o && targets == 8, "R9", "original range completed", targets, 8);
      chk(mem[12'h300] == 8'hFF, "R9", "second range untouched", mem[12'h300], 8'hFF);
      repeat (20) @(negedge clk);
      chk(n_done == d0 + 1 && !busy_o, "R9", "no second run", n_done - d0, 1);

      // R11: source address tracks target after a fresh run
      run_ok(12'h0A0, 12'h0A2);
      chk(src_addr_o == 12'h0A2, "R11", "source address holds last target", src_addr_o, 12'h0A2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule